// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block translates a 32-bit virtual address into a physical address in the same cycle as the request. It holds a fully associative set of page translations, each tagged with a 6-bit address-space number, so that the entries of several processes live side by side and a process switch needs no invalidation. The top three address bits select a segment. Two segments (user space and kernel mapped space) are looked up in the translation store. Two kernel segments bypass it and map straight onto the low physical window, one cached and one uncached.

A lookup that finds no entry raises a miss fault. A kernel-only segment touched in user mode raises an address-error fault. A store to a page whose writeable bit is clear raises a modify fault. There is no hardware table walk. Software refills the store through an indexed write port, and the write becomes visible on the following cycle.

Top module: `asid_tlb`

## Requirements
- R1: The store has 64 entries, and any page may sit at any index. An entry written at index 0 or index 63 is found by a lookup.
- R2: A non-global entry matches only when the virtual page number `lookupVaddr[31:12]` and the 6-bit address-space number both match. Bits [11:0] pass to `physAddr[11:0]` unchanged.
- R3: An entry with its global bit set matches a lookup with any address-space number.
- R4: In the translated segments (`lookupVaddr[31]`=0, or `lookupVaddr[31:30]`=11), a hit gives `physAddr` = {entry frame, offset} and `physUncached` = the entry's no-cache bit.
- R5: With `lookupVaddr[31:29]`=100 in kernel mode, the store is bypassed. `physAddr` = {000, `lookupVaddr[28:0]`}, `physUncached`=0, `xlateOk`=1 and no fault is raised.
- R6: With `lookupVaddr[31:29]`=101 in kernel mode, the translation is as in R5, but `physUncached`=1.
- R7: A translated lookup that matches no valid entry raises `faultMiss`, and `xlateOk` stays 0.
- R8: In user mode, any address with bit 31 set raises `faultAddrErr` alone, with no miss or modify fault. At most one fault output is high at a time.
- R9: A store (`lookupStore`=1) that hits an entry whose writeable bit is clear raises `faultModify` and clears `xlateOk`. A load to the same page succeeds.
- R10: A write through the indexed port takes effect at the next clock edge. A lookup in the same cycle as the write sees the old contents of the entry.
- R11: Reset invalidates every entry, so that translated lookups miss until software refills the store.
- R12: When several valid entries match, the entry with the lowest index supplies the translation.
- R13: When `lookupValid` is 0, all fault outputs and `xlateOk` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | A translation request is present |
| lookupVaddr | input | 32 | Virtual address to translate |
| lookupAsid | input | 6 | Address-space number of the request |
| lookupStore | input | 1 | The request is a store |
| userMode | input | 1 | The request comes from user mode |
| wrEn | input | 1 | Load one entry of the store |
| wrIndex | input | 6 | Entry index to load |
| wrVpn | input | 20 | Virtual page number of the new entry |
| wrAsid | input | 6 | Address-space number of the new entry |
| wrPfn | input | 20 | Physical frame number of the new entry |
| wrValid | input | 1 | Valid bit of the new entry |
| wrGlobal | input | 1 | Global bit of the new entry (ignore the address-space number) |
| wrDirty | input | 1 | Writeable bit of the new entry |
| wrNoCache | input | 1 | No-cache bit of the new entry |
| physAddr | output | 32 | Translated physical address |
| physUncached | output | 1 | The access must bypass the caches |
| xlateOk | output | 1 | The translation succeeded without a fault |
| faultMiss | output | 1 | No entry matched (software refill needed) |
| faultAddrErr | output | 1 | A kernel segment was accessed in user mode |
| faultModify | output | 1 | A store hit a page that is not writeable |

## Verification
The refill write and the combinational lookup can fall in the same cycle, even on the very entry being replaced. The bench drives a write to index 0 together with a lookup of the old page in one cycle. It expects the old frame in that cycle, then a miss on the old page and a hit on the new one in the next cycle. Fault precedence is judged in the same way, by issuing a user-mode request to a kernel-mapped page that has a valid global entry and requiring only the address-error fault.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    SEG_USER_MAP,
    SEG_KERN_PHYS,
    SEG_KERN_PHYS_NC,
    SEG_KERN_MAP
  } seg_t;

  typedef struct packed {
    logic mapSel;
    logic bypassNc;
    logic loadEntry;
  } tlb_strobe_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lookupValid,
  input  logic [2:0]  segBits,
  input  logic        userMode,
  input  logic        lookupStore,
  input  logic        wrEn,
  input  logic        matchHit,
  input  logic        matchDirty,
  output tlb_strobe_t strobe,
  output logic        xlateOk,
  output logic        faultMiss,
  output logic        faultAddrErr,
  output logic        faultModify
);

  seg_t segment;
  logic mapped;
  logic anyFault;

  always_comb begin
    if (!segBits[2])           segment = SEG_USER_MAP;
    else if (segBits[1])       segment = SEG_KERN_MAP;
    else if (segBits[0])       segment = SEG_KERN_PHYS_NC;
    else                       segment = SEG_KERN_PHYS;
  end

  assign mapped = (segment == SEG_USER_MAP) || (segment == SEG_KERN_MAP);

  always_comb begin
    strobe.mapSel    = mapped;
    strobe.bypassNc  = (segment == SEG_KERN_PHYS_NC);
    strobe.loadEntry = wrEn;
  end

  assign faultAddrErr = lookupValid && userMode && (segment != SEG_USER_MAP);
  assign faultMiss    = lookupValid && !faultAddrErr && mapped && !matchHit;
  assign faultModify  = lookupValid && !faultAddrErr && mapped && matchHit
                        && lookupStore && !matchDirty;
  assign anyFault     = faultAddrErr || faultMiss || faultModify;
  assign xlateOk      = lookupValid && !anyFault;

  assert_one_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({faultMiss, faultAddrErr, faultModify}));

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |-> !(xlateOk || faultMiss || faultAddrErr || faultModify));

  assert_bypass_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && !userMode && segBits[2:1] == 2'b10) |-> (xlateOk && !faultMiss));

  assert_miss_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    faultMiss |-> (!xlateOk && !matchHit));

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int ASID_W      = 6,
  parameter int VPN_W       = 20,
  parameter int OFF_W       = 12,
  localparam int VA_W       = VPN_W + OFF_W,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int SEG_W      = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  tlb_strobe_t       strobe,
  input  logic [VA_W-1:0]   lookupVaddr,
  input  logic [ASID_W-1:0] lookupAsid,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [VPN_W-1:0]  wrPfn,
  input  logic              wrValid,
  input  logic              wrGlobal,
  input  logic              wrDirty,
  input  logic              wrNoCache,
  output logic              matchHit,
  output logic              matchDirty,
  output logic [VA_W-1:0]   physAddr,
  output logic              physUncached
);

  logic [NUM_ENTRIES-1:0] vldQ, gblQ, dirtyQ, ncQ;
  logic [VPN_W-1:0]       vpnQ  [NUM_ENTRIES];
  logic [VPN_W-1:0]       pfnQ  [NUM_ENTRIES];
  logic [ASID_W-1:0]      asidQ [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]       selIdx;
  logic [VPN_W-1:0]       reqVpn;

  assign reqVpn = lookupVaddr[VA_W-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vldQ   <= '0;
      gblQ   <= '0;
      dirtyQ <= '0;
      ncQ    <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        vpnQ[i]  <= '0;
        pfnQ[i]  <= '0;
        asidQ[i] <= '0;
      end
    end else if (strobe.loadEntry) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (wrIndex == IDX_W'(i)) begin
          vldQ[i]   <= wrValid;
          gblQ[i]   <= wrGlobal;
          dirtyQ[i] <= wrDirty;
          ncQ[i]    <= wrNoCache;
          vpnQ[i]   <= wrVpn;
          pfnQ[i]   <= wrPfn;
          asidQ[i]  <= wrAsid;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : gMatch
      assign matchVec[g] = vldQ[g] && (vpnQ[g] == reqVpn)
                           && (gblQ[g] || (asidQ[g] == lookupAsid));
    end
  endgenerate

  always_comb begin
    selIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign matchHit   = |matchVec;
  assign matchDirty = dirtyQ[selIdx];

  always_comb begin
    if (strobe.mapSel) begin
      physAddr     = {pfnQ[selIdx], lookupVaddr[OFF_W-1:0]};
      physUncached = ncQ[selIdx];
    end else begin
      physAddr     = {{SEG_W{1'b0}}, lookupVaddr[VA_W-SEG_W-1:0]};
      physUncached = strobe.bypassNc;
    end
  end

  // shadow of the last load, used to check write timing
  logic             chkLoad;
  logic [IDX_W-1:0] chkIdx;
  logic             chkVld;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chkLoad <= 1'b0;
      chkIdx  <= '0;
      chkVld  <= 1'b0;
    end else begin
      chkLoad <= strobe.loadEntry;
      chkIdx  <= wrIndex;
      chkVld  <= wrValid;
    end
  end

  assert_load_next_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chkLoad |-> (vldQ[chkIdx] == chkVld));

  assert_reset_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vldQ == '0));

  assert_bypass_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.mapSel |-> (physAddr[VA_W-1 -: SEG_W] == '0));

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    physAddr[OFF_W-1:0] == lookupVaddr[OFF_W-1:0]);

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int ASID_W      = 6,
  parameter int VPN_W       = 20,
  parameter int OFF_W       = 12,
  localparam int VA_W       = VPN_W + OFF_W,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   lookupVaddr,
  input  logic [ASID_W-1:0] lookupAsid,
  input  logic              lookupStore,
  input  logic              userMode,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIndex,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [VPN_W-1:0]  wrPfn,
  input  logic              wrValid,
  input  logic              wrGlobal,
  input  logic              wrDirty,
  input  logic              wrNoCache,
  output logic [VA_W-1:0]   physAddr,
  output logic              physUncached,
  output logic              xlateOk,
  output logic              faultMiss,
  output logic              faultAddrErr,
  output logic              faultModify
);

  tlb_strobe_t strobe;
  logic        matchHit;
  logic        matchDirty;

  tlb_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookupValid  (lookupValid),
    .segBits      (lookupVaddr[VA_W-1 -: 3]),
    .userMode     (userMode),
    .lookupStore  (lookupStore),
    .wrEn         (wrEn),
    .matchHit     (matchHit),
    .matchDirty   (matchDirty),
    .strobe       (strobe),
    .xlateOk      (xlateOk),
    .faultMiss    (faultMiss),
    .faultAddrErr (faultAddrErr),
    .faultModify  (faultModify)
  );

  tlb_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ASID_W      (ASID_W),
    .VPN_W       (VPN_W),
    .OFF_W       (OFF_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .lookupVaddr  (lookupVaddr),
    .lookupAsid   (lookupAsid),
    .wrIndex      (wrIndex),
    .wrVpn        (wrVpn),
    .wrAsid       (wrAsid),
    .wrPfn        (wrPfn),
    .wrValid      (wrValid),
    .wrGlobal     (wrGlobal),
    .wrDirty      (wrDirty),
    .wrNoCache    (wrNoCache),
    .matchHit     (matchHit),
    .matchDirty   (matchDirty),
    .physAddr     (physAddr),
    .physUncached (physUncached)
  );

  assert_store_clean_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && lookupStore && !userMode && !lookupVaddr[VA_W-1] && matchHit && !matchDirty)
      |-> (faultModify && !xlateOk));

endmodule

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
module sim_asid_tlb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVaddr = '0;
  logic [5:0]  lookupAsid = '0;
  logic        lookupStore = 1'b0;
  logic        userMode = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIndex = '0;
  logic [19:0] wrVpn = '0;
  logic [5:0]  wrAsid = '0;
  logic [19:0] wrPfn = '0;
  logic        wrValid = 1'b0;
  logic        wrGlobal = 1'b0;
  logic        wrDirty = 1'b0;
  logic        wrNoCache = 1'b0;
  logic [31:0] physAddr;
  logic        physUncached, xlateOk, faultMiss, faultAddrErr, faultModify;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  asid_tlb u0 (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
    .lookupAsid(lookupAsid), .lookupStore(lookupStore), .userMode(userMode),
    .wrEn(wrEn), .wrIndex(wrIndex), .wrVpn(wrVpn), .wrAsid(wrAsid), .wrPfn(wrPfn),
    .wrValid(wrValid), .wrGlobal(wrGlobal), .wrDirty(wrDirty), .wrNoCache(wrNoCache),
    .physAddr(physAddr), .physUncached(physUncached), .xlateOk(xlateOk),
    .faultMiss(faultMiss), .faultAddrErr(faultAddrErr), .faultModify(faultModify)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // status word: {ok, miss, addrErr, modify}
  function automatic logic [31:0] status();
    return {28'd0, xlateOk, faultMiss, faultAddrErr, faultModify};
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic writeEntry(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                            input logic [19:0] pfn, input logic v, input logic g,
                            input logic d, input logic nc);
    @(negedge clk);
    wrEn = 1; wrIndex = 6'(idx); wrVpn = vpn; wrAsid = asid; wrPfn = pfn;
    wrValid = v; wrGlobal = g; wrDirty = d; wrNoCache = nc;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [5:0] asid, input logic user, input logic st);
    @(negedge clk);
    lookupValid = 1; lookupVaddr = va; lookupAsid = asid; userMode = user; lookupStore = st;
    #1;
  endtask

  task automatic testReset();
    lookup(32'h0040_0123, 6'd1, 1'b1, 1'b0);
    check("R11", "status after reset", status(), 32'b0100);
    check("R7", "miss status", status(), 32'b0100);
  endtask

  task automatic testEdges();
    writeEntry(0, 20'h00400, 6'd1, 20'h12345, 1, 0, 1, 0);
    writeEntry(63, 20'h7FFFF, 6'd2, 20'h00ABC, 1, 0, 1, 1);
    lookup(32'h0040_0ABC, 6'd1, 1'b1, 1'b0);
    check("R1", "idx0 status", status(), 32'b1000);
    check("R4", "idx0 paddr", physAddr, 32'h1234_5ABC);
    check("R4", "idx0 cached", {31'd0, physUncached}, 32'd0);
    lookup(32'h7FFF_F001, 6'd2, 1'b1, 1'b0);
    check("R1", "idx63 paddr", physAddr, 32'h00AB_C001);
    check("R4", "idx63 uncached", {31'd0, physUncached}, 32'd1);
    check("R2", "offset passes", {20'd0, physAddr[11:0]}, 32'h001);
  endtask

  task automatic testAsid();
    lookup(32'h0040_0ABC, 6'd2, 1'b1, 1'b0);
    check("R2", "asid mismatch", status(), 32'b0100);
  endtask

  task automatic testGlobal();
    writeEntry(10, 20'hC0001, 6'd3, 20'h55555, 1, 1, 1, 0);
    lookup(32'hC000_1010, 6'd7, 1'b0, 1'b0);
    check("R3", "global status", status(), 32'b1000);
    check("R3", "global paddr", physAddr, 32'h5555_5010);
  endtask

  task automatic testBypass();
    lookup(32'h8123_4567, 6'd9, 1'b0, 1'b1);
    check("R5", "cached bypass status", status(), 32'b1000);
    check("R5", "cached bypass paddr", physAddr, 32'h0123_4567);
    check("R5", "cached bypass flag", {31'd0, physUncached}, 32'd0);
    lookup(32'hA123_4567, 6'd9, 1'b0, 1'b0);
    check("R6", "uncached bypass paddr", physAddr, 32'h0123_4567);
    check("R6", "uncached bypass flag", {31'd0, physUncached}, 32'd1);
  endtask

  task automatic testUserErr();
    lookup(32'h8123_4567, 6'd1, 1'b1, 1'b0);
    check("R8", "user kseg phys", status(), 32'b0010);
    lookup(32'hC000_1010, 6'd1, 1'b1, 1'b1);
    check("R8", "user kseg mapped global", status(), 32'b0010);
  endtask

  task automatic testModify();
    writeEntry(20, 20'h00500, 6'd1, 20'h00777, 1, 0, 0, 0);
    lookup(32'h0050_0004, 6'd1, 1'b1, 1'b0);
    check("R9", "clean load", status(), 32'b1000);
    check("R9", "clean load paddr", physAddr, 32'h0077_7004);
    lookup(32'h0050_0004, 6'd1, 1'b1, 1'b1);
    check("R9", "clean store", status(), 32'b0001);
    lookup(32'h0040_0ABC, 6'd1, 1'b1, 1'b1);
    check("R9", "dirty store", status(), 32'b1000);
  endtask

  task automatic testPriority();
    writeEntry(40, 20'h00600, 6'd1, 20'h22222, 1, 0, 1, 0);
    writeEntry(30, 20'h00600, 6'd1, 20'h11111, 1, 0, 1, 0);
    lookup(32'h0060_0123, 6'd1, 1'b0, 1'b0);
    check("R12", "lowest index wins", physAddr, 32'h1111_1123);
    writeEntry(30, 20'h00600, 6'd1, 20'h11111, 0, 0, 1, 0);
    lookup(32'h0060_0123, 6'd1, 1'b0, 1'b0);
    check("R12", "next index after invalidate", physAddr, 32'h2222_2123);
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    wrEn = 1; wrIndex = 6'd0; wrVpn = 20'h00900; wrAsid = 6'd1; wrPfn = 20'h0AAAA;
    wrValid = 1; wrGlobal = 0; wrDirty = 1; wrNoCache = 0;
    lookupValid = 1; lookupVaddr = 32'h0040_0ABC; lookupAsid = 6'd1; userMode = 1; lookupStore = 0;
    #1;
    check("R10", "old entry same cycle", physAddr, 32'h1234_5ABC);
    check("R10", "old entry status", status(), 32'b1000);
    @(posedge clk); #1;
    wrEn = 0;
    lookup(32'h0040_0ABC, 6'd1, 1'b1, 1'b0);
    check("R10", "old page gone", status(), 32'b0100);
    lookup(32'h0090_0ABC, 6'd1, 1'b1, 1'b0);
    check("R10", "new page paddr", physAddr, 32'h0AAA_AABC);
  endtask

  task automatic testIdle();
    @(negedge clk);
    lookupValid = 0; lookupVaddr = 32'hC000_0000; userMode = 1; lookupStore = 1;
    #1;
    check("R13", "idle status", status(), 32'b0000);
  endtask

  task automatic testReReset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    lookup(32'h0090_0ABC, 6'd1, 1'b1, 1'b0);
    check("R11", "refilled page gone after reset", status(), 32'b0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    testReset();
    testEdges();
    testAsid();
    testGlobal();
    testBypass();
    testUserErr();
    testModify();
    testPriority();
    testSameCycle();
    testIdle();
    testReReset();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish();
  end

endmodule